// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt lines into one request towards a processor. Each line is latched into a status register, either when it rises (edge capture) or for as long as it is high (level capture). The capture mode of every line is fixed at build time by a mask parameter. Latched requests pass through an enable register to form the pending set. The block raises its single request output when any request is pending and both bits of a two-bit master control register are set.

Software reaches the block through a small 32-bit register bus with separate read and write strobes. Enable bits may be loaded outright, or set and cleared atomically through two write-one alias addresses, so no read-modify-write is needed. Latched status bits are cleared by writing ones to an acknowledge address. A vector register gives the number of the lowest-numbered pending line, so line 0 has the highest priority. When nothing is pending it reads all ones.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master registers and the read data are zero, irq_out is low, and the vector register reads 0xFFFFFFFF.
- R2: A write to byte offset 0x08 loads the enable register with the write data, and a read of 0x08 returns it.
- R3: A write to byte offset 0x10 ORs the write data into the enable register and leaves the other bits unchanged.
- R4: A write to byte offset 0x14 clears every enable bit where the write data has a one and leaves the other bits unchanged.
- R5: A write to byte offset 0x0C clears each status bit whose data bit is one, unless that line sets its bit in the same cycle. All ones clears every latched bit. Reads of 0x0C, 0x10 and 0x14 return zero.
- R6: A line whose EDGE_MASK bit is 1 sets its status bit (offset 0x00, bit n for line n) when a clock samples it high after it was sampled low. The bit then holds until acknowledged, whatever the line does. A new edge in the same cycle as the acknowledge leaves the bit set.
- R7: A line whose EDGE_MASK bit is 0 sets its status bit in every cycle it is sampled high, so an acknowledge while it is still high leaves the bit set.
- R8: A read of byte offset 0x04 returns status AND enable.
- R9: A read of byte offset 0x18 returns the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R10: Byte offset 0x1C holds a master control value: bit 0 is the global enable and bit 1 the hardware request enable. irq_out is high exactly when both bits are set and at least one bit is pending.
- R11: Writes to byte offsets 0x00, 0x04 and 0x18 change no register.
- R12: rd_data takes the value of the addressed register, as it stood before the clock edge at which bus_rd is sampled high, and holds it until the next read. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NSRC (32) | Interrupt lines, sampled on the clock |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Directed patterns come first. A line is held high across an acknowledge, once in edge mode and once in level mode; only level mode keeps the bit. An edge arriving in the same cycle as its acknowledge shows that the new edge wins. Several lines are latched together under varying enables, which tells the lowest-index vector apart from any other pick, and an empty pending set must give all ones. A long pseudo-random run then mixes line toggles with writes and reads at every offset, including the read-only ones. A behavioural model is compared with rd_data and irq_out on every cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned BUS_DATA_W = 32;

    // Word index taken from byte offset bits [4:2]; software depends on these values.
    typedef enum logic [2:0] {
        RI_STATUS  = 3'd0,
        RI_PENDING = 3'd1,
        RI_ENABLE  = 3'd2,
        RI_ACK     = 3'd3,
        RI_EN_SET  = 3'd4,
        RI_EN_CLR  = 3'd5,
        RI_VECTOR  = 3'd6,
        RI_MASTER  = 3'd7
    } reg_idx_e;

    localparam int unsigned MST_GLOBAL_BIT = 0;
    localparam int unsigned MST_HWREQ_BIT  = 1;

endpackage

// File: rtl/irq_capture_bank.sv
module irq_capture_bank #(
    parameter int unsigned NSRC = 32,
    parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] status_o
);

    typedef struct packed {
        logic [NSRC-1:0] status;
        logic [NSRC-1:0] prev;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic [NSRC-1:0] set_w;

    // Per-line capture variant chosen by the mask.
    for (genvar g = 0; g < NSRC; g++) begin : g_line
        if (EDGE_MASK[g]) begin : g_edge
            assign set_w[g] = src_i[g] & ~state_q.prev[g];
        end else begin : g_level
            assign set_w[g] = src_i[g];
        end
    end

    always_comb begin
        state_d        = state_q;
        state_d.prev   = src_i;
        // A new request beats an acknowledge in the same cycle.
        state_d.status = set_w | (state_q.status & ~ack_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;

    // R5: an acknowledged bit without a competing request is gone next cycle
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.status & $past(ack_i & ~set_w)) == '0));

    // R6: latched bits persist until acknowledged
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.status & $past(state_q.status & ~ack_i))
                  == $past(state_q.status & ~ack_i)));

    // R7: a level line that is high always shows up as latched
    a_r7_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.status & $past(src_i & ~EDGE_MASK))
                  == $past(src_i & ~EDGE_MASK)));

endmodule

// File: rtl/irq_lowest_finder.sv
module irq_lowest_finder #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // Scan downwards so the lowest index is the last to be written.
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = BUS_DATA_W,
    parameter logic [NSRC-1:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0]   enable;
        logic [1:0]        master;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    reg_idx_e          widx;
    logic [NSRC-1:0]   wmask;
    logic [NSRC-1:0]   ack_vec;
    logic [NSRC-1:0]   status;
    logic [NSRC-1:0]   pending;
    logic              vec_found;
    logic [IDX_W-1:0]  vec_idx;
    logic [DATA_W-1:0] vec_word;
    logic [DATA_W-1:0] rd_mux;

    assign widx    = reg_idx_e'(bus_addr[4:2]);
    assign wmask   = bus_wdata[NSRC-1:0];
    assign ack_vec = (bus_wr && widx == RI_ACK) ? wmask : '0;

    irq_capture_bank #(
        .NSRC      (NSRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (irq_src),
        .ack_i    (ack_vec),
        .status_o (status)
    );

    assign pending = status & state_q.enable;

    irq_lowest_finder #(
        .W     (NSRC),
        .IDX_W (IDX_W)
    ) u_finder (
        .req_i   (pending),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    assign vec_word = vec_found ? DATA_W'(vec_idx) : '1;

    always_comb begin
        unique case (widx)
            RI_STATUS:  rd_mux = DATA_W'(status);
            RI_PENDING: rd_mux = DATA_W'(pending);
            RI_ENABLE:  rd_mux = DATA_W'(state_q.enable);
            RI_VECTOR:  rd_mux = vec_word;
            RI_MASTER:  rd_mux = DATA_W'(state_q.master);
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (bus_rd) begin
            state_d.rdata = rd_mux;
        end
        if (bus_wr) begin
            case (widx)
                RI_ENABLE: state_d.enable = wmask;
                RI_EN_SET: state_d.enable = state_q.enable | wmask;
                RI_EN_CLR: state_d.enable = state_q.enable & ~wmask;
                RI_MASTER: state_d.master = bus_wdata[1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign irq_out   = state_q.master[MST_GLOBAL_BIT] & state_q.master[MST_HWREQ_BIT]
                       & (|pending);

    // R2: direct load of the enable register
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == RI_ENABLE) |=> (state_q.enable == $past(wmask)));

    // R3: set alias never drops a requested bit
    a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == RI_EN_SET) |=>
            ((state_q.enable & $past(wmask)) == $past(wmask)));

    // R4: clear alias removes every requested bit
    a_r4_clear_and: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == RI_EN_CLR) |=> ((state_q.enable & $past(wmask)) == '0));

    // R10: a master value lacking either bit silences the request
    a_r10_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == RI_MASTER && bus_wdata[1:0] != 2'b11) |=> !irq_out);

    // R11: writes to read-only offsets leave control state alone
    a_r11_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (widx inside {RI_STATUS, RI_PENDING, RI_VECTOR})) |=>
            ($stable(state_q.enable) && $stable(state_q.master)));

    // R9: the reported index is pending and no lower index is
    always_comb begin
        if (rst_n && vec_found) begin
            a_r9_idx_active: assert (pending[vec_idx]);
            a_r9_idx_lowest: assert ((pending & ~(pending - NSRC'(1)))
                                     == (NSRC'(1) << vec_idx));
        end
    end

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    localparam logic [31:0] EDGES = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_src;
    logic [4:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic        irq_out;

    always #10 clk = ~clk;

    irq_vector_ctrl #(
        .NSRC      (32),
        .ADDR_W    (5),
        .DATA_W    (32),
        .EDGE_MASK (EDGES)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Behavioural reference state
    logic [31:0] m_st, m_en, m_prev, m_rd;
    logic [1:0]  m_me;
    logic [31:0] cur_src;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [31:0] m_vector(input logic [31:0] p);
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return m_st;
            3'd1: return m_st & m_en;
            3'd2: return m_en;
            3'd6: return m_vector(m_st & m_en);
            3'd7: return {30'd0, m_me};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a[4:2])
            3'd0: return "R6";
            3'd1: return "R8";
            3'd2: return "R2";
            3'd3: return "R5";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [4:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] ack;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; irq_src = cur_src;
        if (rd) m_rd = m_read(a);
        ack = (wr && a[4:2] == 3'd3) ? d : 32'd0;
        for (int i = 0; i < 32; i++) begin
            logic s;
            s = EDGES[i] ? (cur_src[i] && !m_prev[i]) : cur_src[i];
            m_st[i] = s || (m_st[i] && !ack[i]);
        end
        if (wr) begin
            case (a[4:2])
                3'd2: m_en = d;
                3'd4: m_en = m_en | d;
                3'd5: m_en = m_en & ~d;
                3'd7: m_me = d[1:0];
                default: ;
            endcase
        end
        m_prev = cur_src;
        @(posedge clk);
        #1;
        check(tag, bus_rdata, m_rd);
        check("R10", {31'd0, irq_out}, {31'd0, (m_me == 2'b11) && ((m_st & m_en) != 0)});
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'd0, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; irq_src = '0; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
        m_st = '0; m_en = '0; m_prev = '0; m_rd = '0; m_me = '0; cur_src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", bus_rdata, 32'd0);
        check("R1", {31'd0, irq_out}, 32'd0);
        for (int k = 0; k < 8; k++) rd(5'(k * 4), "R1");
        rd(5'h18, "R1");
        @(negedge clk);
        check("R1", bus_rdata, 32'hFFFF_FFFF);

        // R2 / R3 / R4: enable handling
        wr(5'h08, 32'hFFFF_FFFF, "R2"); rd(5'h08, "R2");
        wr(5'h08, 32'h0000_00F0, "R2"); rd(5'h08, "R2");
        wr(5'h10, 32'h0000_000F, "R3"); rd(5'h08, "R3");
        wr(5'h14, 32'h0000_0030, "R4"); rd(5'h08, "R4");
        rd(5'h10, "R5"); rd(5'h14, "R5"); rd(5'h0C, "R5");

        // R6: edge line 3 held high across an acknowledge
        cur_src = 32'h0000_0008; rd(5'h00, "R6"); rd(5'h00, "R6");
        wr(5'h0C, 32'h0000_0008, "R6"); rd(5'h00, "R6");
        cur_src = 32'h0; rd(5'h00, "R6");
        cur_src = 32'h0000_0008; wr(5'h0C, 32'h0000_0008, "R6"); rd(5'h00, "R6");

        // R7: level line 20 held high across an acknowledge
        cur_src = 32'h0010_0000; rd(5'h00, "R7");
        wr(5'h0C, 32'h0010_0000, "R7"); rd(5'h00, "R7");
        cur_src = 32'h0; wr(5'h0C, 32'h0010_0000, "R7"); rd(5'h00, "R7");

        // R8 / R9 / R10: pending, vector and request gating
        cur_src = 32'h0010_0020; rd(5'h00, "R8");
        cur_src = 32'h0010_0000;
        wr(5'h08, 32'h0010_0020, "R8"); rd(5'h04, "R8"); rd(5'h18, "R9");
        wr(5'h1C, 32'h1, "R10"); wr(5'h1C, 32'h3, "R10"); wr(5'h1C, 32'h2, "R10");
        wr(5'h1C, 32'h3, "R10"); rd(5'h1C, "R10");
        wr(5'h14, 32'h0000_0020, "R9"); rd(5'h18, "R9");
        wr(5'h08, 32'h0, "R9"); rd(5'h18, "R9"); rd(5'h04, "R8");

        // R11: writes to read-only offsets
        wr(5'h00, 32'hFFFF_FFFF, "R11"); wr(5'h04, 32'hFFFF_FFFF, "R11");
        wr(5'h18, 32'hFFFF_FFFF, "R11"); rd(5'h00, "R11"); rd(5'h08, "R11");

        // R5: clear everything; R12: low address bits ignored, data held
        cur_src = 32'h0; wr(5'h0C, 32'hFFFF_FFFF, "R5"); rd(5'h03, "R12");
        step(1'b0, 1'b0, 5'h08, 32'd0, "R12");

        // Pseudo-random traffic
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 600; n++) begin
            logic [4:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] == 4'd0) cur_src = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            a = {lfsr[9:7], lfsr[5:4]};
            step(lfsr[11] & lfsr[12], lfsr[13], a,
                 {lfsr[7:0], lfsr[31:8]}, tag_of(a));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule